// File: doc/BRIEF.md
# LIN Master Frame Transmitter

This block is the transmit half of a UART with LIN support, used by a bus master. On request it drives a long low break on the line, then a one-bit high delimiter. After that it sends whatever bytes software gives it: the synch value 0x55, the identifier, and any response data and checksum. It builds no checksum and no identifier parity. It only frames and serialises the bytes that arrive in its single-byte holding register.

Software writes a byte while `hold_empty` is high. `line_idle` goes high once nothing remains to be sent. A byte that is written while the break is running waits until the delimiter ends. A byte written while the previous character is still shifting follows it with only the stop bits in between. One pulse on `baud_tick` marks each bit time, and every change on the line happens at such a pulse. The `stop_two` input picks one or two stop bits per character.

Top module: `lin_master_tx`

## Requirements
- R1: After reset `tx_out` is 1, `hold_empty` is 1 and `line_idle` is 1.
- R2: A `brk_start` pulse taken while `line_idle` is 1 makes `tx_out` go low at the next `baud_tick`. The line stays low for BRK_BITS bit times (BRK_BITS is at least 13), then goes high for exactly one bit time as the delimiter.
- R3: A `brk_start` pulse while `line_idle` is 0 is ignored. No break follows the character in flight.
- R4: Each character is sent as one low start bit, then the DATA_W data bits with bit 0 first, then the stop bits, which are high. Each of these bits lasts one `baud_tick` period.
- R5: With `stop_two` = 0 a character has one stop bit. With `stop_two` = 1 it has two.
- R6: A write taken while `hold_empty` is 1 clears `hold_empty`. The flag sets again when the shifter takes the byte. A write while `hold_empty` is 0 is ignored: the held byte stays unchanged and the extra byte is never sent.
- R7: A byte written after a break is requested does not start until the delimiter is over. Its start bit begins at the tick that ends the delimiter.
- R8: A byte written before the previous character finishes is sent straight after that character's last stop bit, with no idle bit between them.
- R9: When no byte is waiting, the line stays high and `line_idle` is 1. A later write starts its start bit at the first `baud_tick` after the write.
- R10: `line_idle` is 0 from the start of a break until the tick that ends the last stop bit of the last queued character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| stop_two | input | 1 | 0: one stop bit, 1: two stop bits |
| brk_start | input | 1 | Single-cycle request to send a break |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to be sent |
| tx_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can take a byte |
| line_idle | output | 1 | Nothing queued, shifting or breaking |

## Verification
Full frames (break, synch, identifier and two data bytes) are sent for all 256 identifier values with one stop bit, and for a spread of values with two stop bits. Every identifier bit, both stop-bit counts and the break-to-synch handover are compared bit by bit. Each such frame writes the synch byte during the break and chains the rest, so it separates held-back writes from early starts and chained characters from ones with extra idle time. Separate runs cover four cases: a write while the register is full, a break request while busy, a gap between single characters with its start latency, and the reset state. These tell ignored strobes apart from accepted ones and show how idle time differs from chaining.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } sh_state_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_WAIT  = 2'd1,
    BK_LOW   = 2'd2,
    BK_DELIM = 2'd3
  } bk_state_e;

  localparam int MIN_BREAK_BITS = 13;

endpackage

// File: rtl/lin_tx_rst_sync.sv
module lin_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lin_tx_hold.sv
module lin_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q;
  logic              full_d;
  logic [DATA_W-1:0] data_q;
  logic              hold_we;

  assign hold_we = wr_en && !full_q;

  always_comb begin
    full_d = full_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (hold_we) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (hold_we) begin
      data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

  AST_HOLD_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R6
  AST_HOLD_FULL_UNTIL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> full_q); // R6

endmodule

// File: rtl/lin_tx_brk.sv
module lin_tx_brk #(
  parameter int BRK_LEN = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic req,
  input  logic sh_idle,
  output logic line_low,
  output logic delim,
  output logic block,
  output logic busy
);
  import lin_tx_pkg::*;

  localparam int CNT_W = (BRK_LEN > 2) ? $clog2(BRK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BRK_LEN - 1);

  bk_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      BK_IDLE: begin
        if (req) begin
          st_d = BK_WAIT;
        end
      end
      BK_WAIT: begin
        if (baud_tick && sh_idle) begin
          st_d   = BK_LOW;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      BK_LOW: begin
        if (baud_tick) begin
          if (cnt_q == LAST_CNT) begin
            st_d = BK_DELIM;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      BK_DELIM: begin
        if (baud_tick) begin
          st_d = BK_IDLE;
        end
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BK_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign line_low = (st_q == BK_LOW);
  assign delim    = (st_q == BK_DELIM);
  assign block    = (st_q == BK_WAIT) || (st_q == BK_LOW);
  assign busy     = (st_q != BK_IDLE);

  AST_BRK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT); // R2
  AST_BRK_WAITS_SHIFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_WAIT && !sh_idle) |=> (st_q != BK_LOW)); // R10

endmodule

// File: rtl/lin_tx_shift.sv
module lin_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              stop_two,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              blocked,
  output logic              take,
  output logic              idle,
  output logic              line
);
  import lin_tx_pkg::*;

  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sh_state_e         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              stp_q, stp_d;
  logic              can_load;
  logic              last_stop;

  assign can_load  = hold_full && !blocked;
  assign last_stop = stop_two ? stp_q : 1'b1;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    stp_d = stp_q;
    take  = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (can_load) begin
          st_d = SH_START;
          sh_d = hold_data;
          take = baud_tick;
        end
      end
      SH_START: begin
        st_d  = SH_DATA;
        bit_d = '0;
      end
      SH_DATA: begin
        sh_d = sh_q >> 1;
        if (bit_q == LAST_BIT) begin
          st_d  = SH_STOP;
          stp_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      SH_STOP: begin
        if (last_stop) begin
          if (can_load) begin
            st_d = SH_START;
            sh_d = hold_data;
            take = baud_tick;
          end else begin
            st_d = SH_IDLE;
          end
        end else begin
          stp_d = 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      stp_q <= 1'b0;
    end else if (baud_tick) begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      stp_q <= stp_d;
    end
  end

  assign idle = (st_q == SH_IDLE);
  assign line = (st_q == SH_START) ? 1'b0 :
                (st_q == SH_DATA)  ? sh_q[0] : 1'b1;

  AST_SH_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(line)); // R4

endmodule

// File: rtl/lin_master_tx.sv
module lin_master_tx #(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              stop_two,
  input  logic              brk_start,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_out,
  output logic              hold_empty,
  output logic              line_idle
);
  import lin_tx_pkg::*;

  localparam int BRK_LEN = (BRK_BITS < MIN_BREAK_BITS) ? MIN_BREAK_BITS : BRK_BITS;

  logic              rst_sync_n;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              sh_idle;
  logic              sh_line;
  logic              brk_low;
  logic              brk_delim;
  logic              brk_block;
  logic              brk_busy;
  logic              brk_req;

  lin_tx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lin_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  lin_tx_brk #(.BRK_LEN(BRK_LEN)) u_brk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .baud_tick (baud_tick),
    .req       (brk_req),
    .sh_idle   (sh_idle),
    .line_low  (brk_low),
    .delim     (brk_delim),
    .block     (brk_block),
    .busy      (brk_busy)
  );

  lin_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .baud_tick (baud_tick),
    .stop_two  (stop_two),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .blocked   (brk_block),
    .take      (take),
    .idle      (sh_idle),
    .line      (sh_line)
  );

  assign line_idle  = !hold_full && sh_idle && !brk_busy;
  assign brk_req    = brk_start && line_idle;
  assign hold_empty = !hold_full;
  assign tx_out     = brk_low ? 1'b0 : sh_line;

  AST_BRK_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_low |-> sh_idle); // R7
  AST_DELIM_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_delim |-> tx_out); // R2
  AST_TXE_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(line_idle) |-> tx_out); // R10

endmodule

// File: tb/lin_master_tx_tb.sv
module lin_master_tx_tb_top;

  localparam int N   = 4;
  localparam int BRK = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       stop_two;
  logic       brk_start;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       tx_out;
  logic       hold_empty;
  logic       line_idle;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int tcnt  = 0;

  logic       exp_bits [0:511];
  int         nexp;
  logic [7:0] wq [0:3];
  int         wn;

  lin_master_tx #(.DATA_W(8), .BRK_BITS(BRK)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .stop_two   (stop_two),
    .brk_start  (brk_start),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tx_out     (tx_out),
    .hold_empty (hold_empty),
    .line_idle  (line_idle)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tcnt      <= (tcnt == N - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == N - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_char(input logic [7:0] b, input logic s2);
    exp_bits[nexp] = 1'b0; nexp++;
    for (int i = 0; i < 8; i++) begin exp_bits[nexp] = b[i]; nexp++; end
    exp_bits[nexp] = 1'b1; nexp++;
    if (s2) begin exp_bits[nexp] = 1'b1; nexp++; end
  endtask

  task automatic add_break();
    for (int i = 0; i < BRK; i++) begin exp_bits[nexp] = 1'b0; nexp++; end
    exp_bits[nexp] = 1'b1; nexp++;
  endtask

  task automatic push_writes();
    for (int k = 0; k < wn; k++) begin
      do @(negedge clk); while (!hold_empty);
      wr_en   = 1'b1;
      wr_data = wq[k];
      @(negedge clk);
      wr_en   = 1'b0;
    end
  endtask

  // Waits for the first low bit, then samples one point per bit time.
  task automatic capture(input string req, input int max_wait);
    int waited = 0;
    int mism = 0;
    int first = -1;
    logic txe_first = 1'b1;
    logic txe_last = 1'b1;
    @(negedge clk);
    while (tx_out !== 1'b0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (max_wait > 0)
      check(waited <= max_wait, "R9 start latency", waited, max_wait);
    for (int i = 0; i < nexp; i++) begin
      if (tx_out !== exp_bits[i]) begin
        mism++;
        if (first < 0) first = i;
      end
      if (i == 0) txe_first = line_idle;
      if (i == nexp - 1) txe_last = line_idle;
      repeat (N) @(negedge clk);
    end
    check(mism == 0, {req, " bit sequence, first bad bit index in actual"}, first, -1);
    check(txe_first == 1'b0 && txe_last == 1'b0, "R10 line_idle low while busy",
          int'(txe_first) + int'(txe_last), 0);
    check(line_idle == 1'b1 && tx_out == 1'b1, "R10 line_idle high after last stop",
          int'(line_idle), 1);
  endtask

  task automatic pulse_break();
    @(negedge clk);
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
  endtask

  task automatic run_frame(input bit do_brk, input logic s2, input string req, input int max_wait);
    stop_two = s2;
    nexp = 0;
    if (do_brk) add_break();
    for (int k = 0; k < wn; k++) add_char(wq[k], s2);
    if (do_brk) pulse_break();
    fork
      push_writes();
      capture(req, max_wait);
    join
  endtask

  task automatic quiet_bits(input int nbits, input string req);
    int lows = 0;
    for (int i = 0; i < nbits * N; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1 || line_idle !== 1'b1) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    stop_two  = 1'b0;
    brk_start = 1'b0;
    wr_en     = 1'b0;
    wr_data   = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tx_out == 1'b1, "R1 tx_out after reset", int'(tx_out), 1);
    check(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
    check(line_idle == 1'b1, "R1 line_idle after reset", int'(line_idle), 1);

    // R2 R4 R5 R7 R8: full frames, synch written during the break, rest chained
    for (int id = 0; id < 256; id++) begin
      wn = 4;
      wq[0] = 8'h55; wq[1] = 8'(id); wq[2] = 8'(id) ^ 8'hA5; wq[3] = ~8'(id);
      run_frame(1'b1, 1'b0, "R2 R4 R7 R8 one stop", 0);
    end
    for (int id = 3; id < 256; id += 9) begin
      wn = 4;
      wq[0] = 8'h55; wq[1] = 8'(id); wq[2] = 8'(id * 3); wq[3] = 8'(id) ^ 8'h3C;
      run_frame(1'b1, 1'b1, "R5 two stop bits", 0);
    end

    // R6: write while full is ignored
    stop_two = 1'b0;
    nexp = 0;
    add_break();
    add_char(8'hC3, 1'b0);
    pulse_break();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    check(hold_empty == 1'b0, "R6 hold_empty cleared by write", int'(hold_empty), 0);
    wr_en = 1'b1; wr_data = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    check(hold_empty == 1'b0, "R6 hold_empty still low", int'(hold_empty), 0);
    capture("R6 only first byte sent", 0);
    quiet_bits(20, "R6 extra byte never sent");

    // R3: break request during a character is ignored
    nexp = 0;
    add_char(8'h96, 1'b0);
    wn = 1; wq[0] = 8'h96;
    fork
      push_writes();
      capture("R3 character without break", 0);
      begin
        do @(negedge clk); while (line_idle);
        repeat (3 * N) @(negedge clk);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
      end
    join
    quiet_bits(20, "R3 no break after ignored request");

    // R9: idle gap between single characters, start latency
    for (int g = 0; g < 4; g++) begin
      wn = 1; wq[0] = 8'(8'h21 + 8'(g * 37));
      run_frame(1'b0, 1'(g % 2), "R9 single char after idle", N + 2);
      quiet_bits(3 + g, "R9 line stays high in gap");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule